// File: doc/BRIEF.md
# Audio DMA Half/Full Buffer Interrupt Controller

This block holds two DMA address generators for an audio port. One serves playback and one serves record. Each generator moves a current word address through a circular buffer. The buffer is bounded by a base register and an end register, both inclusive. The current address restarts at base after the transfer made at end. A transfer happens on a clock edge where the path's request output and its acknowledge input are both high. Software can refill one half of the buffer while hardware uses the other half, because the block flags a path when it transfers at the buffer midpoint and again when it transfers at the buffer end.

A control register holds several fields: the enable, the FIFO threshold choice, the link-select bit and the two sticky flags. The flags are cleared by writing 1. Each flag drives an active-low interrupt line. Requests are driven by FIFO occupancy. Playback asks for a word when its FIFO has drained to the threshold. Record asks for a transfer when its FIFO has filled to the threshold.

Top module: `audio_dma_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, both interrupt lines are high, both request outputs are low and link_sel is low.
- R2: While enabled, each transfer advances that path's current address by 4. The transfer made while the current address equals end loads base instead. An acknowledge without a request moves nothing.
- R3: The midpoint is base plus (((end − base) − 1) / 2, integer division, rounded down to a multiple of 4). It is base when end equals base. A transfer made at the midpoint or at end sets that path's flag on the same edge. The flag holds the matching interrupt line low: play_irq_n for playback, rec_irq_n for record.
- R4: Control register (reg_sel 0): bit 8 is the playback flag and bit 9 is the record flag. Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R5: When a flag-setting transfer and a write-1 clear of the same flag fall on the same edge, the flag ends up set.
- R6: Control bit 0 enables both paths. Control bit 1 selects the threshold: 8 when 0, 4 when 1. play_req is high exactly when the block is enabled and play_lvl ≤ threshold.
- R7: rec_req is high exactly when the block is enabled and rec_lvl ≥ threshold.
- R8: Control bit 2 is read/write and drives link_sel directly.
- R9: Register map: 1 = playback base, 2 = playback end, 3 = record base, 4 = record end, 5 = playback current (read only), 6 = record current (read only), 7 = none. Unused bits read 0. Address writes drop bits 1:0 and all bits at or above AW. Control bits other than 0, 1, 2, 8 and 9 read 0.
- R10: While disabled, writing a base or end register moves that path's current address to its base. While enabled, such writes leave the current address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| play_lvl | input | LVL_W | Playback FIFO occupancy |
| rec_lvl | input | LVL_W | Record FIFO occupancy |
| play_req | output | 1 | Playback word request (valid) |
| play_ack | input | 1 | Playback transfer acknowledge |
| play_addr | output | AW | Playback current address |
| rec_req | output | 1 | Record word request (valid) |
| rec_ack | input | 1 | Record transfer acknowledge |
| rec_addr | output | AW | Record current address |
| play_irq_n | output | 1 | Playback interrupt, active low |
| rec_irq_n | output | 1 | Record interrupt, active low |
| link_sel | output | 1 | Serial link select |

## Verification
The bench builds the block with AW = 8 and LVL_W = 5. With these values every buffer length from one to eight words can be swept at three base offsets, including one near the top of the address space. Each sweep runs more than two laps, so the midpoint rounding, the wrap and the one-word case (midpoint equal to end) all come up on both paths. The 5-bit level lets both thresholds be checked against every occupancy value from 0 to 31.

// File: rtl/adic_pkg.sv
package adic_pkg;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_PCUR = 3'd5;
  localparam logic [2:0] SEL_RCUR = 3'd6;

  localparam int BIT_EN   = 0;
  localparam int BIT_THR4 = 1;
  localparam int BIT_LINK = 2;
  localparam int BIT_PFLG = 8;
  localparam int BIT_RFLG = 9;

  // Midpoint of an inclusive word buffer, on a word boundary.
  function automatic logic [31:0] mid_addr(input logic [31:0] b, input logic [31:0] e);
    logic [31:0] half;
    if (e == b) return b;
    half = ((e - b) - 32'd1) >> 1;
    return b + (half & ~32'd3);
  endfunction

endpackage

// File: rtl/adic_addr_gen.sv
module adic_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we_base,
  input  logic          we_end,
  input  logic [AW-1:0] wdata,
  input  logic          xfer,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] end_o,
  output logic [AW-1:0] cur_o,
  output logic          hit_o
);
  localparam logic [AW-1:0] STEP  = AW'(4);
  localparam logic [AW-1:0] ALIGN = ~AW'(3);

  logic [AW-1:0] base_q, end_q, cur_q, mid;
  logic [AW-1:0] wdata_al;

  assign wdata_al = wdata & ALIGN;
  assign mid      = AW'(adic_pkg::mid_addr(32'(base_q), 32'(end_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      end_q  <= '0;
      cur_q  <= '0;
    end else begin
      if (we_base) base_q <= wdata_al;
      if (we_end)  end_q  <= wdata_al;
      if (!en && we_base)    cur_q <= wdata_al;
      else if (!en && we_end) cur_q <= base_q;
      else if (xfer)          cur_q <= (cur_q == end_q) ? base_q : cur_q + STEP;
    end
  end

  assign hit_o  = xfer && ((cur_q == mid) || (cur_q == end_q));
  assign base_o = base_q;
  assign end_o  = end_q;
  assign cur_o  = cur_q;
endmodule

// File: rtl/adic_fifo_req.sv
module adic_fifo_req #(
  parameter int LVL_W  = 5,
  parameter int THR_HI = 8,
  parameter int THR_LO = 4,
  parameter bit IS_REC = 1'b0
) (
  input  logic             en,
  input  logic             thr4,
  input  logic [LVL_W-1:0] lvl,
  output logic             req
);
  localparam logic [LVL_W-1:0] T_HI = LVL_W'(THR_HI);
  localparam logic [LVL_W-1:0] T_LO = LVL_W'(THR_LO);

  logic [LVL_W-1:0] thr;
  assign thr = thr4 ? T_LO : T_HI;

  generate
    if (IS_REC) begin : g_fill
      assign req = en && (lvl >= thr);
    end else begin : g_drain
      assign req = en && (lvl <= thr);
    end
  endgenerate
endmodule

// File: rtl/adic_ctrl_reg.sv
module adic_ctrl_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic [1:0]  hit,
  output logic        en,
  output logic        thr4,
  output logic        link,
  output logic [1:0]  flag
);
  import adic_pkg::*;

  logic [1:0] clr;
  assign clr = {2{we}} & {wdata[BIT_RFLG], wdata[BIT_PFLG]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      thr4 <= 1'b0;
      link <= 1'b0;
      flag <= 2'b00;
    end else begin
      if (we) begin
        en   <= wdata[BIT_EN];
        thr4 <= wdata[BIT_THR4];
        link <= wdata[BIT_LINK];
      end
      flag <= hit | (flag & ~clr);
    end
  end
endmodule

// File: rtl/audio_dma_irq_ctrl.sv
module audio_dma_irq_ctrl #(
  parameter int AW     = 16,
  parameter int LVL_W  = 5,
  parameter int THR_HI = 8,
  parameter int THR_LO = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [LVL_W-1:0] play_lvl,
  input  logic [LVL_W-1:0] rec_lvl,
  output logic             play_req,
  input  logic             play_ack,
  output logic [AW-1:0]    play_addr,
  output logic             rec_req,
  input  logic             rec_ack,
  output logic [AW-1:0]    rec_addr,
  output logic             play_irq_n,
  output logic             rec_irq_n,
  output logic             link_sel
);
  import adic_pkg::*;

  localparam int NPATH = 2;

  logic             en, thr4, link;
  logic [1:0]       flag;
  logic [NPATH-1:0] req, ack, xfer, hit;
  logic [LVL_W-1:0] lvl       [NPATH];
  logic [AW-1:0]    path_base [NPATH];
  logic [AW-1:0]    path_end  [NPATH];
  logic [AW-1:0]    path_cur  [NPATH];
  logic             ctrl_we;
  logic             unused_wdata;

  assign ctrl_we      = reg_we && (reg_sel == SEL_CTRL);
  assign unused_wdata = ^{reg_wdata[31:10], reg_wdata[7:3]};
  assign ack          = {rec_ack, play_ack};
  assign lvl[0]       = play_lvl;
  assign lvl[1]       = rec_lvl;

  generate
    for (genvar p = 0; p < NPATH; p++) begin : g_path
      localparam logic [2:0] SEL_B = 3'(1 + 2 * p);
      localparam logic [2:0] SEL_E = 3'(2 + 2 * p);

      adic_fifo_req #(
        .LVL_W (LVL_W), .THR_HI(THR_HI), .THR_LO(THR_LO), .IS_REC(p == 1)
      ) u_req (
        .en(en), .thr4(thr4), .lvl(lvl[p]), .req(req[p])
      );

      assign xfer[p] = req[p] && ack[p];

      adic_addr_gen #(.AW(AW)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .we_base (reg_we && (reg_sel == SEL_B)),
        .we_end  (reg_we && (reg_sel == SEL_E)),
        .wdata   (reg_wdata[AW-1:0]),
        .xfer    (xfer[p]),
        .base_o  (path_base[p]),
        .end_o   (path_end[p]),
        .cur_o   (path_cur[p]),
        .hit_o   (hit[p])
      );
    end
  endgenerate

  adic_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctrl_we),
    .wdata (reg_wdata),
    .hit   (hit),
    .en    (en),
    .thr4  (thr4),
    .link  (link),
    .flag  (flag)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[BIT_EN]   = en;
        reg_rdata[BIT_THR4] = thr4;
        reg_rdata[BIT_LINK] = link;
        reg_rdata[BIT_PFLG] = flag[0];
        reg_rdata[BIT_RFLG] = flag[1];
      end
      3'd1:     reg_rdata[AW-1:0] = path_base[0];
      3'd2:     reg_rdata[AW-1:0] = path_end[0];
      3'd3:     reg_rdata[AW-1:0] = path_base[1];
      3'd4:     reg_rdata[AW-1:0] = path_end[1];
      SEL_PCUR: reg_rdata[AW-1:0] = path_cur[0];
      SEL_RCUR: reg_rdata[AW-1:0] = path_cur[1];
      default:  reg_rdata = '0;
    endcase
  end

  assign play_req   = req[0];
  assign rec_req    = req[1];
  assign play_addr  = path_cur[0];
  assign rec_addr   = path_cur[1];
  assign play_irq_n = ~flag[0];
  assign rec_irq_n  = ~flag[1];
  assign link_sel   = link;
endmodule

// File: rtl/audio_dma_irq_ctrl_chk.sv
module audio_dma_irq_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          reg_we,
  input logic          play_xfer,
  input logic          rec_xfer,
  input logic          play_hit,
  input logic          rec_hit,
  input logic          play_irq_n,
  input logic          rec_irq_n,
  input logic          play_req,
  input logic          rec_req,
  input logic [AW-1:0] play_addr,
  input logic [AW-1:0] play_base,
  input logic [AW-1:0] play_end
);
  // R3: an interrupt only asserts after a qualifying transfer
  p_set_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(play_irq_n) |-> $past(play_hit));
  p_set_cause_rec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rec_irq_n) |-> $past(rec_hit));
  // R5: a set event always leaves the flag set
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    play_hit |=> !play_irq_n);
  p_set_wins_rec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_hit |=> !rec_irq_n);
  // R2: wrap after the end address, step otherwise
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (play_xfer && play_addr == play_end) |=> play_addr == $past(play_base));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (play_xfer && play_addr != play_end) |=> play_addr == $past(play_addr) + AW'(4));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!play_xfer && !reg_we) |=> $stable(play_addr));
  // R6, R7: no request while disabled
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!play_req && !rec_req));
endmodule

bind audio_dma_irq_ctrl audio_dma_irq_ctrl_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .reg_we     (reg_we),
  .play_xfer  (xfer[0]),
  .rec_xfer   (xfer[1]),
  .play_hit   (hit[0]),
  .rec_hit    (hit[1]),
  .play_irq_n (play_irq_n),
  .rec_irq_n  (rec_irq_n),
  .play_req   (play_req),
  .rec_req    (rec_req),
  .play_addr  (play_addr),
  .play_base  (path_base[0]),
  .play_end   (path_end[0])
);

// File: tb/audio_dma_irq_ctrl_bench.sv
`timescale 1ns/1ps
module audio_dma_irq_ctrl_bench;
  localparam int AW = 8;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_sel = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [LW-1:0] play_lvl = '0, rec_lvl = '0;
  logic          play_req, rec_req, play_ack = 1'b0, rec_ack = 1'b0;
  logic [AW-1:0] play_addr, rec_addr;
  logic          play_irq_n, rec_irq_n, link_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  audio_dma_irq_ctrl #(.AW(AW), .LVL_W(LW)) u_audio_dma_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .play_lvl(play_lvl), .rec_lvl(rec_lvl),
    .play_req(play_req), .play_ack(play_ack), .play_addr(play_addr),
    .rec_req(rec_req), .rec_ack(rec_ack), .rec_addr(rec_addr),
    .play_irq_n(play_irq_n), .rec_irq_n(rec_irq_n), .link_sel(link_sel)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  task automatic xfer(input bit rec);
    @(negedge clk);
    if (rec) rec_ack = 1'b1; else play_ack = 1'b1;
    @(negedge clk);
    play_ack = 1'b0; rec_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int bases [3] = '{0, 32'h24, 32'hE0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int s = 0; s < 8; s++) begin
      rd(3'(s), v);
      chk(v == 0, "R1 reg", v, 0);
    end
    chk(play_irq_n && rec_irq_n, "R1 irq", {play_irq_n, rec_irq_n}, 2'b11);
    chk(!play_req && !rec_req && !link_sel, "R1 req/link", {play_req, rec_req, link_sel}, 0);

    // R6, R7: threshold sweep, both settings and disabled
    for (int t = 0; t < 3; t++) begin
      int thr;
      thr = (t == 1) ? 4 : 8;
      wr(0, (t == 2) ? 32'h0 : (32'h1 | (t == 1 ? 32'h2 : 32'h0)));
      for (int l = 0; l < 32; l++) begin
        play_lvl = LW'(l); rec_lvl = LW'(l);
        #1;
        chk(play_req == (t != 2 && l <= thr), "R6 play_req", play_req, (t != 2 && l <= thr));
        chk(rec_req == (t != 2 && l >= thr), "R7 rec_req", rec_req, (t != 2 && l >= thr));
      end
    end

    // R8: link select
    wr(0, 32'h4);
    rd(0, v);
    chk(link_sel == 1'b1 && v == 32'h4, "R8 link set", {link_sel, v[7:0]}, 9'h104);
    wr(0, 32'h0);
    chk(link_sel == 1'b0, "R8 link clear", link_sel, 0);

    // R9: reserved bits and address alignment
    wr(0, 32'hFFFF_FCF8);
    rd(0, v);
    chk(v == 0, "R9 ctrl reserved", v, 0);
    wr(1, 32'hFFFF_FFFF);
    rd(1, v);
    chk(v == 32'hFC, "R9 base align", v, 32'hFC);
    rd(7, v);
    chk(v == 0, "R9 sel7", v, 0);
    wr(5, 32'h40);
    rd(5, v);
    chk(v == 32'hFC, "R9 cur read-only", v, 32'hFC);

    // R2, R3, R4, R10: buffer sweep on both paths
    play_lvl = '0; rec_lvl = '1;
    for (int p = 0; p < 2; p++) begin
      for (int bi = 0; bi < 3; bi++) begin
        for (int n = 1; n <= 8; n++) begin
          int b, e, m, ex;
          bit hit;
          b = bases[bi];
          e = b + 4 * (n - 1);
          m = (n == 1) ? b : b + 4 * ((n - 2) / 2);
          wr(0, 32'h300);
          wr(3'(1 + 2 * p), 32'(b));
          wr(3'(2 + 2 * p), 32'(e));
          rd(3'(5 + p), v);
          chk(v == 32'(b), "R10 restart", v, b);
          wr(0, 32'h1);
          ex = b;
          for (int k = 0; k < 2 * n + 1; k++) begin
            logic [AW-1:0] a;
            a = p ? rec_addr : play_addr;
            chk(a == AW'(ex), "R2 addr", a, ex);
            xfer(p[0]);
            hit = (ex == m) || (ex == e);
            chk((p ? rec_irq_n : play_irq_n) == !hit, "R3 irq", p ? rec_irq_n : play_irq_n, !hit);
            if (hit) begin
              wr(0, 32'h1 | (p ? 32'h200 : 32'h100));
              chk((p ? rec_irq_n : play_irq_n) == 1'b1, "R4 clear", 0, 1);
            end
            ex = (ex == e) ? b : ex + 4;
          end
        end
      end
    end

    // R2: acknowledge without request moves nothing
    play_lvl = '1;
    #1;
    v = 32'(play_addr);
    xfer(1'b0);
    chk(32'(play_addr) == v, "R2 ack without req", play_addr, v);
    play_lvl = '0;

    // R10: base write while enabled leaves current address
    v = 32'(rec_addr);
    wr(3, 32'h80);
    chk(32'(rec_addr) == v, "R10 enabled write", rec_addr, v);

    // R5 and R4: one-word playback buffer, every transfer sets the flag
    wr(0, 32'h300);
    wr(1, 32'h10);
    wr(2, 32'h10);
    wr(0, 32'h1);
    xfer(1'b0);
    chk(play_irq_n == 1'b0, "R3 one-word", play_irq_n, 0);
    wr(0, 32'h1);
    rd(0, v);
    chk(play_irq_n == 1'b0 && v == 32'h101, "R4 write 0 keeps", v, 32'h101);
    @(negedge clk);
    play_ack = 1'b1; reg_we = 1'b1; reg_sel = 0; reg_wdata = 32'h101;
    @(negedge clk);
    play_ack = 1'b0; reg_we = 1'b0;
    chk(play_irq_n == 1'b0, "R5 set wins", play_irq_n, 0);
    chk(rec_irq_n == 1'b1, "R4 other flag untouched", rec_irq_n, 1);
    wr(0, 32'h101);
    chk(play_irq_n == 1'b1, "R4 clear after", play_irq_n, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule